// File: doc/BRIEF.md
# Dual-Mode Memory and Port Address Decoder

This block sits on the bus side of an 8-bit processor system and turns each bus cycle into chip selects. Every cycle carries an address, two space strobes (one marking a memory cycle, one marking a port cycle) and separate read and write strobes. From these the block produces a memory select, a one-hot set of peripheral port selects, and read and write enables for whichever target was chosen. All outputs are registered, so they appear one clock after the strobes are sampled.

A static mode input picks one of two address maps. In isolated mode ports live in their own 256-entry space, reached only by port cycles that use address bits 7..0, and memory cycles select memory over the full 64 KB. In unified mode there is no separate port space. A 256-byte aligned window of the memory map (default 0xFF00 to 0xFFFF) reaches the ports instead of memory. A port strobe from the processor is then folded onto the memory side, so both strobe kinds decode the same way.

A word-transfer input pairs an even port with the odd port above it as one 16-bit port, with the even port on the low byte lane and the odd port on the high lane. The block also returns port read data on a 16-bit bus. A lane that no implemented port drives reads as 0xFF.

Top module: `memio_decoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, every select, enable and error output is 0 after that edge, whatever the strobes are.
- R2: In isolated mode (unified_mode=0), a cycle with mem_req=1, io_req=0 and exactly one of rd_strb/wr_strb selects memory at every 16-bit address. After the next edge mem_sel=1, mem_rd_en equals rd_strb, mem_wr_en equals wr_strb, and no port select is set.
- R3: In isolated mode, a cycle with io_req=1, mem_req=0 and one direction strobe is a port cycle whose port number is addr[7:0]. Bits 15..8 have no effect. Port n, for n < N_PORTS, gets port_sel[n]=1, and port_rd_en or port_wr_en follows the strobe.
- R4: In unified mode, a memory cycle whose addr[15:8] equals WIN_BASE[15:8] is a port cycle with port number addr[7:0] and mem_sel=0. Any other address selects memory.
- R5: In unified mode, a cycle with io_req=1 and mem_req=0 decodes exactly as the same cycle with mem_req=1 would.
- R6: A word port cycle (word_xfer=1) at an even port number n selects ports n and n+1 (each if implemented). On a read, rd_data[7:0] carries port n data and rd_data[15:8] carries port n+1 data.
- R7: A word port cycle at an odd port number sets word_err=1. It sets no port select and no port or memory enable.
- R8: A cycle with both space strobes, or with one space strobe and both rd_strb and wr_strb, sets bus_err=1. It sets no select or enable.
- R9: A port cycle to a port number at or above N_PORTS sets no select, but the port enable still follows the strobe. Every byte lane not driven by a selected port reads 0xFF, so a byte read puts 0xFF on rd_data[15:8].
- R10: A cycle with neither space strobe, or with neither direction strobe, leaves every select, enable and error output at 0.
- R11: mem_sel and any port select are never 1 together, and at most two port selects are 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unified_mode | input | 1 | 1 = ports mapped into memory window, 0 = separate port space |
| addr | input | ADDR_W | Bus address |
| mem_req | input | 1 | Memory-cycle strobe, active high |
| io_req | input | 1 | Port-cycle strobe, active high |
| rd_strb | input | 1 | Read strobe, active high |
| wr_strb | input | 1 | Write strobe, active high |
| word_xfer | input | 1 | 16-bit port transfer |
| port_rdata | input | N_PORTS*8 | Read data of each port, port i at bits 8i+7..8i |
| mem_sel | output | 1 | Memory chip select |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| port_sel | output | N_PORTS | Port selects |
| port_rd_en | output | 1 | Port read enable |
| port_wr_en | output | 1 | Port write enable |
| word_err | output | 1 | Word port cycle at odd port number |
| bus_err | output | 1 | Conflicting strobes |
| rd_data | output | 16 | Port read data, low and high byte lanes |

## Verification
A behavioural model in the bench predicts every output for each cycle, and the bench compares against it on every clock. Directed cycles come first. The same addresses are run in both modes, which separates the window decode from the separate port space. Isolated port cycles with varied upper address bits show whether those bits are really ignored. Word cycles at even, odd and out-of-range port numbers separate lane pairing, alignment errors and the 0xFF fill. Conflicting-strobe and idle cycles show that the error path and the quiet path do not leak selects. A long stretch of random strobe, mode and address mixes then looks for interactions the directed cycles miss.

// File: rtl/memio_pkg.sv
// Package: shared widths and the per-cycle classification record used by the
// memory/port decoder. Assumes an 8-bit port number field.
package memio_pkg;

    localparam int unsigned PORT_AW = 8;
    localparam int unsigned BYTE_W  = 8;

    // What a sampled bus cycle turned out to be.
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_MEM  = 2'd1,
        CYC_PORT = 2'd2,
        CYC_ERR  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e            kind;
        logic                 rd;
        logic                 wr;
        logic                 word;
        logic [PORT_AW-1:0]   port_num;
    } cyc_info_t;

endpackage

// File: rtl/memio_space_sel.sv
// Module: memio_space_sel
// Classifies the current bus cycle as idle, memory, port or error. In unified
// mode both space strobes are folded onto the memory side and the port window
// is carved out of the memory map. Assumes WIN_BASE is 256-byte aligned;
// only its upper byte is compared. Purely combinational.
module memio_space_sel
    import memio_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFF00
) (
    input  logic              unified_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    input  logic              rd_strb,
    input  logic              wr_strb,
    input  logic              word_xfer,
    output cyc_info_t         info
);

    logic any_space;
    logic conflict;
    logic one_dir;
    logic in_window;

    assign any_space = mem_req | io_req;
    assign conflict  = (mem_req & io_req) | (any_space & rd_strb & wr_strb);
    assign one_dir   = rd_strb ^ wr_strb;
    assign in_window = (addr[ADDR_W-1:PORT_AW] == WIN_BASE[ADDR_W-1:PORT_AW]);

    // Decide the cycle kind and carry direction and port number along.
    always_comb begin
        info          = '0;
        info.kind     = CYC_NONE;
        info.port_num = addr[PORT_AW-1:0];
        info.word     = word_xfer;
        if (conflict) begin
            info.kind = CYC_ERR;
        end else if (any_space && one_dir) begin
            info.rd = rd_strb;
            info.wr = wr_strb;
            if (unified_mode) begin
                info.kind = in_window ? CYC_PORT : CYC_MEM;
            end else begin
                info.kind = mem_req ? CYC_MEM : CYC_PORT;
            end
        end
    end

endmodule

// File: rtl/memio_port_decode.sv
// Module: memio_port_decode
// Turns a classified port cycle into per-port selects and byte-lane tags.
// Byte cycles select port n; word cycles at even n select n and n+1, the odd
// one on the high lane. Odd word bases raise an alignment error. Port numbers
// at or above N_PORTS select nothing. Purely combinational.
module memio_port_decode
    import memio_pkg::*;
#(
    parameter int unsigned N_PORTS = 8
) (
    input  cyc_info_t            info,
    output logic [N_PORTS-1:0]   sel,
    output logic [N_PORTS-1:0]   hi_lane,
    output logic                 rd_en,
    output logic                 wr_en,
    output logic                 align_err
);

    logic               is_port;
    logic               bad_align;
    logic               good;
    logic [PORT_AW-1:0] pair_num;

    assign is_port   = (info.kind == CYC_PORT);
    assign bad_align = info.word & info.port_num[0];
    assign good      = is_port & ~bad_align;
    assign pair_num  = {info.port_num[PORT_AW-1:1], 1'b1};
    assign rd_en     = good & info.rd;
    assign wr_en     = good & info.wr;
    assign align_err = is_port & bad_align;

    // One comparator pair per implemented port.
    for (genvar i = 0; i < int'(N_PORTS); i++) begin : g_port
        localparam logic [PORT_AW-1:0] NUM = PORT_AW'(i);
        logic hit_lo;
        logic hit_hi;
        assign hit_lo     = (info.port_num == NUM);
        assign hit_hi     = info.word & (pair_num == NUM);
        assign sel[i]     = good & (hit_lo | hit_hi);
        assign hi_lane[i] = info.word & NUM[0];
    end

endmodule

// File: rtl/memio_rdata_mux.sv
// Module: memio_rdata_mux
// Steers the read data of the selected ports onto the 16-bit return bus.
// A lane no selected port drives reads 0xFF. Assumes at most one port per
// lane, which the decoder guarantees. Purely combinational.
module memio_rdata_mux
    import memio_pkg::*;
#(
    parameter int unsigned N_PORTS = 8
) (
    input  logic [N_PORTS-1:0]        sel,
    input  logic [N_PORTS-1:0]        hi_lane,
    input  logic                      rd_en,
    input  logic [N_PORTS*BYTE_W-1:0] port_rdata,
    output logic [2*BYTE_W-1:0]       rd_data
);

    // Collect each lane from the single port selected for it.
    always_comb begin
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        lo = '1;
        hi = '1;
        for (int i = 0; i < int'(N_PORTS); i++) begin
            if (rd_en && sel[i]) begin
                if (hi_lane[i]) hi = port_rdata[i*BYTE_W +: BYTE_W];
                else            lo = port_rdata[i*BYTE_W +: BYTE_W];
            end
        end
        rd_data = {hi, lo};
    end

endmodule

// File: rtl/memio_decoder.sv
// Module: memio_decoder
// Top of the dual-mode memory/port decoder. Classifies each bus cycle,
// decodes port selects, and registers all selects, enables and error flags
// on the clock edge that samples the strobes. Read data is steered from the
// registered selects. Assumes strobes are stable around the sampling edge and
// unified_mode changes only between cycles.
module memio_decoder
    import memio_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       N_PORTS  = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFF00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      unified_mode,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      mem_req,
    input  logic                      io_req,
    input  logic                      rd_strb,
    input  logic                      wr_strb,
    input  logic                      word_xfer,
    input  logic [N_PORTS*BYTE_W-1:0] port_rdata,
    output logic                      mem_sel,
    output logic                      mem_rd_en,
    output logic                      mem_wr_en,
    output logic [N_PORTS-1:0]        port_sel,
    output logic                      port_rd_en,
    output logic                      port_wr_en,
    output logic                      word_err,
    output logic                      bus_err,
    output logic [2*BYTE_W-1:0]       rd_data
);

    cyc_info_t          info;
    logic [N_PORTS-1:0] sel_d;
    logic [N_PORTS-1:0] hi_d;
    logic               prd_d;
    logic               pwr_d;
    logic               aerr_d;
    logic               is_mem;
    logic [N_PORTS-1:0] hi_q;

    memio_space_sel #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) i_space (
        .unified_mode (unified_mode),
        .addr         (addr),
        .mem_req      (mem_req),
        .io_req       (io_req),
        .rd_strb      (rd_strb),
        .wr_strb      (wr_strb),
        .word_xfer    (word_xfer),
        .info         (info)
    );

    memio_port_decode #(
        .N_PORTS (N_PORTS)
    ) i_ports (
        .info      (info),
        .sel       (sel_d),
        .hi_lane   (hi_d),
        .rd_en     (prd_d),
        .wr_en     (pwr_d),
        .align_err (aerr_d)
    );

    assign is_mem = (info.kind == CYC_MEM);

    // Register every select, enable and flag; clear all of them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel    <= 1'b0;
            mem_rd_en  <= 1'b0;
            mem_wr_en  <= 1'b0;
            port_sel   <= '0;
            hi_q       <= '0;
            port_rd_en <= 1'b0;
            port_wr_en <= 1'b0;
            word_err   <= 1'b0;
            bus_err    <= 1'b0;
        end else begin
            mem_sel    <= is_mem;
            mem_rd_en  <= is_mem & info.rd;
            mem_wr_en  <= is_mem & info.wr;
            port_sel   <= sel_d;
            hi_q       <= hi_d & sel_d;
            port_rd_en <= prd_d;
            port_wr_en <= pwr_d;
            word_err   <= aerr_d;
            bus_err    <= (info.kind == CYC_ERR);
        end
    end

    memio_rdata_mux #(
        .N_PORTS (N_PORTS)
    ) i_rdata (
        .sel        (port_sel),
        .hi_lane    (hi_q),
        .rd_en      (port_rd_en),
        .port_rdata (port_rdata),
        .rd_data    (rd_data)
    );

    // R1: reset clears all outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_sel && !mem_rd_en && !mem_wr_en && port_sel == '0 &&
                    !port_rd_en && !port_wr_en && !word_err && !bus_err));

    // R2: isolated-mode memory read selects memory.
    p_iso_mem_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!unified_mode && mem_req && !io_req && rd_strb && !wr_strb)
        |=> (mem_sel && mem_rd_en && !mem_wr_en && port_sel == '0));

    // R4: unified-mode window hit never selects memory.
    p_win_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unified_mode && (mem_req ^ io_req) && (rd_strb ^ wr_strb) &&
         addr[ADDR_W-1:PORT_AW] == WIN_BASE[ADDR_W-1:PORT_AW])
        |=> (!mem_sel && (port_rd_en || port_wr_en || word_err)));

    // R7: odd word base in isolated mode flags and selects nothing.
    p_odd_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!unified_mode && io_req && !mem_req && (rd_strb ^ wr_strb) &&
         word_xfer && addr[0])
        |=> (word_err && port_sel == '0 && !port_rd_en && !port_wr_en));

    // R8: both space strobes give a bus error only.
    p_dual_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && io_req)
        |=> (bus_err && !mem_sel && port_sel == '0 && !port_rd_en && !port_wr_en));

    // R10: no space strobe leaves the bus quiet.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !io_req)
        |=> (!mem_sel && port_sel == '0 && !port_rd_en && !port_wr_en &&
             !word_err && !bus_err));

    // R11: memory and ports are exclusive; at most two ports at once.
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_sel && port_sel != '0));

    p_pair_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_sel) <= 2);

endmodule

// File: tb/test_memio_decoder.sv
// Bench for memio_decoder: a behavioural model predicts every output for each
// cycle; inputs change on the falling edge, outputs are compared one falling
// edge later (after the registering rising edge).
module test_memio_decoder;

    localparam int NP  = 8;
    localparam int WIN = 16'hFF00;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           unified_mode = 1'b0;
    logic [15:0]    addr = '0;
    logic           mem_req = 1'b0;
    logic           io_req = 1'b0;
    logic           rd_strb = 1'b0;
    logic           wr_strb = 1'b0;
    logic           word_xfer = 1'b0;
    logic [NP*8-1:0] port_rdata;
    logic           mem_sel, mem_rd_en, mem_wr_en;
    logic [NP-1:0]  port_sel;
    logic           port_rd_en, port_wr_en, word_err, bus_err;
    logic [15:0]    rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected values for the cycle in flight.
    int e_msel, e_mrd, e_mwr, e_sel, e_prd, e_pwr, e_werr, e_berr, e_rdata;

    always #4 clk = ~clk;

    memio_decoder #(.ADDR_W(16), .N_PORTS(NP), .WIN_BASE(16'hFF00)) i_memio_decoder (
        .clk(clk), .rst_n(rst_n), .unified_mode(unified_mode), .addr(addr),
        .mem_req(mem_req), .io_req(io_req), .rd_strb(rd_strb), .wr_strb(wr_strb),
        .word_xfer(word_xfer), .port_rdata(port_rdata),
        .mem_sel(mem_sel), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .port_sel(port_sel), .port_rd_en(port_rd_en), .port_wr_en(port_wr_en),
        .word_err(word_err), .bus_err(bus_err), .rd_data(rd_data)
    );

    function automatic int pdata(int p);
        return (8'h30 + p * 17) & 8'hFF;
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) port_rdata[p*8 +: 8] = 8'(pdata(p));
    end

    // Behavioural prediction from the requirements.
    task automatic predict();
        int num, lo, hi, space_on, to_port;
        e_msel = 0; e_mrd = 0; e_mwr = 0; e_sel = 0; e_prd = 0; e_pwr = 0;
        e_werr = 0; e_berr = 0;
        lo = 255; hi = 255;
        space_on = mem_req || io_req;
        if (rst_n) begin
            if ((mem_req && io_req) || (space_on && rd_strb && wr_strb)) begin
                e_berr = 1;
            end else if (space_on && (rd_strb != wr_strb)) begin
                if (unified_mode) to_port = (addr >= WIN) && (addr <= WIN + 255);
                else              to_port = io_req;
                if (!to_port) begin
                    e_msel = 1; e_mrd = rd_strb; e_mwr = wr_strb;
                end else begin
                    num = addr % 256;
                    if (word_xfer && (num % 2 == 1)) begin
                        e_werr = 1;
                    end else begin
                        e_prd = rd_strb; e_pwr = wr_strb;
                        if (num < NP) begin
                            e_sel += 1 << num;
                            if (rd_strb) lo = pdata(num);
                        end
                        if (word_xfer && num + 1 < NP) begin
                            e_sel += 1 << (num + 1);
                            if (rd_strb) hi = pdata(num + 1);
                        end
                    end
                end
            end
        end
        e_rdata = hi * 256 + lo;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle, then compare all outputs after the registering edge.
    task automatic cyc(string tag, bit rn, bit um, int a, bit mq, bit iq,
                       bit r, bit w, bit wd);
        rst_n = rn; unified_mode = um; addr = 16'(a); mem_req = mq; io_req = iq;
        rd_strb = r; wr_strb = w; word_xfer = wd;
        predict();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "mem_sel",    int'(mem_sel),    e_msel);
        chk(tag, "mem_rd_en",  int'(mem_rd_en),  e_mrd);
        chk(tag, "mem_wr_en",  int'(mem_wr_en),  e_mwr);
        chk(tag, "port_sel",   int'(port_sel),   e_sel);
        chk(tag, "port_rd_en", int'(port_rd_en), e_prd);
        chk(tag, "port_wr_en", int'(port_wr_en), e_pwr);
        chk(tag, "word_err",   int'(word_err),   e_werr);
        chk(tag, "bus_err",    int'(bus_err),    e_berr);
        chk(tag, "rd_data",    int'(rd_data),    e_rdata);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: strobes active during reset give nothing.
        cyc("R1", 0, 0, 16'h0003, 0, 1, 1, 0, 0);
        cyc("R1", 0, 1, 16'h1234, 1, 0, 0, 1, 0);
        // R2: isolated memory cycles, including window addresses.
        cyc("R2", 1, 0, 16'h0000, 1, 0, 1, 0, 0);
        cyc("R2", 1, 0, 16'hFF02, 1, 0, 0, 1, 0);
        cyc("R2", 1, 0, 16'hFFFF, 1, 0, 1, 0, 0);
        // R3: isolated port cycles; upper bits must not matter.
        cyc("R3", 1, 0, 16'h0005, 0, 1, 1, 0, 0);
        cyc("R3", 1, 0, 16'hA505, 0, 1, 1, 0, 0);
        cyc("R3", 1, 0, 16'h7F00, 0, 1, 0, 1, 0);
        // R4: unified window hit and miss.
        cyc("R4", 1, 1, 16'hFF03, 1, 0, 1, 0, 0);
        cyc("R4", 1, 1, 16'hFE03, 1, 0, 1, 0, 0);
        cyc("R4", 1, 1, 16'h0003, 1, 0, 0, 1, 0);
        // R5: port strobe in unified mode decodes as memory.
        cyc("R5", 1, 1, 16'h0003, 0, 1, 1, 0, 0);
        cyc("R5", 1, 1, 16'hFF06, 0, 1, 0, 1, 0);
        // R6: word pairs on both lanes.
        cyc("R6", 1, 0, 16'h0002, 0, 1, 1, 0, 1);
        cyc("R6", 1, 1, 16'hFF06, 1, 0, 1, 0, 1);
        cyc("R6", 1, 0, 16'h0000, 0, 1, 0, 1, 1);
        // R7: odd word base.
        cyc("R7", 1, 0, 16'h0003, 0, 1, 1, 0, 1);
        cyc("R7", 1, 1, 16'hFF05, 1, 0, 0, 1, 1);
        // R8: conflicting strobes.
        cyc("R8", 1, 0, 16'h0002, 1, 1, 1, 0, 0);
        cyc("R8", 1, 0, 16'h0002, 0, 1, 1, 1, 0);
        // R9: unimplemented ports and 0xFF fill.
        cyc("R9", 1, 0, 16'h0040, 0, 1, 1, 0, 0);
        cyc("R9", 1, 0, 16'h0008, 0, 1, 1, 0, 1);
        cyc("R9", 1, 1, 16'hFFF0, 1, 0, 0, 1, 0);
        // R10: idle cycles.
        cyc("R10", 1, 0, 16'h0002, 0, 0, 1, 0, 0);
        cyc("R10", 1, 0, 16'h0002, 0, 1, 0, 0, 0);
        // R11: random mix for exclusivity and model agreement.
        for (int k = 0; k < 3000; k++) begin
            int a;
            a = $urandom_range(0, 3) == 0 ? (16'hFF00 | $urandom_range(0, 15))
                                          : ($urandom_range(0, 1) ? $urandom_range(0, 15)
                                                                  : $urandom_range(0, 65535));
            cyc("R11", $urandom_range(0, 40) != 0, 1'($urandom_range(0, 1)), a,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule